// File: doc/BRIEF.md
# LPC Firmware-Memory Target Cycle Decoder

This block is the bus-facing front end of a flash target on a 4-bit LPC bus. It follows the framing strobe and the 4-bit data lines and recognises two cycle families: firmware-memory reads and writes, and standard LPC memory reads and writes. For each cycle it checks the device identity against four strap inputs. For LPC memory cycles it also checks that the address falls in a claimed window. It then steers the access to either the flash core or the register space, and hands a decoded request to the core as a one-clock strobe.

Cycles that fail the identity, range or size checks are dropped silently, and the bus is never driven for them. A framing pulse in the middle of a cycle cancels only that cycle. While the core reports busy, write cycles still run their full handshake on the bus, but no write request reaches the core. The core is represented by a busy flag and a read-data byte.

Top module: `lpc_fwm_decoder`

## Requirements
- R1: During and right after reset, lad_oe and req_valid are 0.
- R2: A firmware-memory read has this sequence: start 1101b with frame_n low, an ID nibble equal to id_strap, 7 address nibbles sent most significant first, then size 0000b. After two turn-around clocks the block drives 0000b. It then drives the read byte, low nibble first, then 1111b for one clock, and then releases the bus.
- R3: A firmware-memory write uses start 1110b. After the size nibble come two data nibbles, low nibble first. The block answers with two turn-around clocks, drives 0000b, drives 1111b, and then releases. The request carries req_write=1 and the byte.
- R4: A firmware-memory cycle whose ID nibble differs from id_strap produces no request and no bus drive.
- R5: A firmware-memory cycle whose size nibble is not 0000b produces no request and no bus drive.
- R6: An LPC memory cycle uses start 0000b. The next nibble is 010xb for a read or 011xb for a write. Eight address nibbles follow, most significant first. The response is the same as in R2 and R3.
- R7: An LPC memory cycle is claimed only if address bits {23,21,20,19} equal id_strap.
- R8: An LPC memory cycle is claimed only if its address lies in FF80_0000h..FFFF_FFFFh or in 000E_0000h..000F_FFFFh.
- R9: req_core equals address bit 22 (1 selects the flash core, 0 selects the register space). req_addr holds the low OFS_W address bits.
- R10: If core_busy is high at the end of the turn-around, a write cycle still completes on the bus but issues no request. Reads are issued regardless of busy.
- R11: frame_n low during a cycle terminates that cycle with no request. With LAD at 1111b the block returns to idle. A cycle resent afterwards is decoded normally.
- R12: A start nibble other than 0000b, 1101b or 1110b is ignored.
- R13: req_valid lasts exactly one clock. For reads it is raised in the first turn-around clock. For writes it is raised in the 0000b drive clock.
- R14: frame_n low in any clock forces lad_oe to 0 in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Cycle framing strobe, active low |
| lad_in | input | 4 | Nibble received from the bus |
| lad_out | output | 4 | Nibble driven onto the bus |
| lad_oe | output | 1 | Bus drive enable |
| id_strap | input | 4 | Device identity straps |
| core_busy | input | 1 | Core is erasing or programming |
| core_rdata | input | 8 | Read byte from the core |
| req_valid | output | 1 | One-clock request strobe |
| req_write | output | 1 | Request is a write |
| req_core | output | 1 | 1 selects flash core, 0 selects register space |
| req_addr | output | OFS_W | Access offset |
| req_wdata | output | 8 | Write byte |

## Verification
A write can reach its commit point in the same clock in which the core turns busy. The bench raises core_busy across write cycles of both families and checks two things: the full 0000b/1111b response still appears on the bus, and the scoreboard receives no item. A read issued under busy must still deliver its request. A framing pulse can also land while the block drives read data. The bench aborts at that point and expects the bus released on the following clock, with the read request already logged.

// File: rtl/lpc_fwm_decoder.sv
module lpc_fwm_decoder #(
  parameter int OFS_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [3:0]       lad_in,
  output logic [3:0]       lad_out,
  output logic             lad_oe,
  input  logic [3:0]       id_strap,
  input  logic             core_busy,
  input  logic [7:0]       core_rdata,
  output logic             req_valid,
  output logic             req_write,
  output logic             req_core,
  output logic [OFS_W-1:0] req_addr,
  output logic [7:0]       req_wdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_CYC, S_IDS, S_ADR, S_MSZ, S_WD, S_TAR, S_SYN, S_RD, S_TB
  } st_t;

  st_t         st;
  logic [2:0]  cnt;
  logic        fwh, wr;
  logic [27:0] addr;
  logic [7:0]  wdata, rdata;

  logic [31:0] nxt_addr;
  logic        id_ok, rng_ok;
  logic [2:0]  last_adr;

  assign nxt_addr = {addr, lad_in};
  assign id_ok    = {nxt_addr[23], nxt_addr[21:19]} == id_strap;
  assign rng_ok   = (&nxt_addr[31:23]) || (nxt_addr[31:17] == 15'h0007);
  assign last_adr = fwh ? 3'd6 : 3'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; fwh <= 1'b0; wr <= 1'b0;
      addr <= '0; wdata <= '0; rdata <= '0; req_valid <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      if (!frame_n) begin
        addr <= '0;
        cnt  <= '0;
        case (lad_in)
          4'b0000: begin st <= S_CYC; fwh <= 1'b0; end
          4'b1101: begin st <= S_IDS; fwh <= 1'b1; wr <= 1'b0; end
          4'b1110: begin st <= S_IDS; fwh <= 1'b1; wr <= 1'b1; end
          default: st <= S_IDLE;
        endcase
      end else begin
        case (st)
          S_CYC:
            if (lad_in[3:2] == 2'b01) begin
              wr <= lad_in[1]; st <= S_ADR; cnt <= '0;
            end else st <= S_IDLE;
          S_IDS:
            if (lad_in == id_strap) begin st <= S_ADR; cnt <= '0; end
            else st <= S_IDLE;
          S_ADR: begin
            addr <= nxt_addr[27:0];
            cnt  <= cnt + 3'd1;
            if (cnt == last_adr) begin
              cnt <= '0;
              if (fwh) st <= S_MSZ;
              else if (id_ok && rng_ok) begin
                st <= wr ? S_WD : S_TAR;
                req_valid <= !wr;
              end else st <= S_IDLE;
            end
          end
          S_MSZ:
            if (lad_in == 4'b0000) begin
              st <= wr ? S_WD : S_TAR;
              req_valid <= !wr;
            end else st <= S_IDLE;
          S_WD:
            if (cnt == 3'd0) begin wdata[3:0] <= lad_in; cnt <= 3'd1; end
            else begin wdata[7:4] <= lad_in; cnt <= '0; st <= S_TAR; end
          S_TAR:
            if (cnt == 3'd0) cnt <= 3'd1;
            else begin
              cnt <= '0; st <= S_SYN; rdata <= core_rdata;
              req_valid <= wr && !core_busy;
            end
          S_SYN: st <= wr ? S_TB : S_RD;
          S_RD:
            if (cnt == 3'd0) cnt <= 3'd1;
            else begin cnt <= '0; st <= S_TB; end
          S_TB:
            if (cnt == 3'd0) cnt <= 3'd1;
            else begin cnt <= '0; st <= S_IDLE; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign lad_oe  = (st == S_SYN) || (st == S_RD) || (st == S_TB && cnt == 3'd0);
  assign lad_out = (st == S_SYN) ? 4'h0 :
                   (st == S_RD)  ? ((cnt == 3'd0) ? rdata[3:0] : rdata[7:4]) : 4'hF;

  assign req_write = wr;
  assign req_core  = addr[22];
  assign req_addr  = addr[OFS_W-1:0];
  assign req_wdata = wdata;

  // R13
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  // R13
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> !lad_oe);
  // R13
  write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (lad_oe && lad_out == 4'h0));
  // R10
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> !$past(core_busy));
  // R14
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);
  // R2
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> lad_out == 4'h0);
endmodule

// File: tb/sim_lpc_fwm_decoder.sv
module sim_lpc_fwm_decoder;
  localparam int CLK_P = 10;
  localparam int OFS_W = 19;

  logic clk = 1'b0, rst_n = 1'b0, frame_n = 1'b1;
  logic [3:0] lad_in = 4'hF, id_strap = 4'hA;
  logic core_busy = 1'b0;
  logic [7:0] core_rdata = 8'h00;
  logic [3:0] lad_out;
  logic lad_oe, req_valid, req_write, req_core;
  logic [OFS_W-1:0] req_addr;
  logic [7:0] req_wdata;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [28:0] q[$];
  string qtag[$];

  always #(CLK_P/2) clk = ~clk;

  lpc_fwm_decoder #(.OFS_W(OFS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .id_strap(id_strap),
    .core_busy(core_busy), .core_rdata(core_rdata), .req_valid(req_valid),
    .req_write(req_write), .req_core(req_core), .req_addr(req_addr),
    .req_wdata(req_wdata));

  // monitor
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      nchk++;
      if (q.size() == 0) begin
        nfail++;
        $display("FAIL unexpected request (R4/R5/R10): got %h expected none",
                 {req_write, req_core, req_addr, req_wdata});
      end else begin
        logic [28:0] e;
        string t;
        e = q.pop_front();
        t = qtag.pop_front();
        if ({req_write, req_core, req_addr} !== e[28:8] ||
            (e[28] && req_wdata !== e[7:0])) begin
          nfail++;
          $display("FAIL %s request: got %h expected %h", t,
                   {req_write, req_core, req_addr, req_wdata}, e);
        end
      end
    end
  end

  task automatic expect_req(input logic w, input logic c, input logic [OFS_W-1:0] a,
                            input logic [7:0] d, input string t);
    q.push_back({w, c, a, d});
    qtag.push_back(t);
  endtask

  task automatic drv(input logic f, input logic [3:0] l);
    @(negedge clk);
    frame_n = f; lad_in = l;
  endtask

  task automatic drvc(input logic f, input logic [3:0] l, input logic eoe,
                      input logic [3:0] eout, input string t);
    @(negedge clk);
    nchk++;
    if (lad_oe !== eoe || (eoe && lad_out !== eout)) begin
      nfail++;
      $display("FAIL %s bus: got oe=%b out=%h expected oe=%b out=%h",
               t, lad_oe, lad_out, eoe, eout);
    end
    frame_n = f; lad_in = l;
  endtask

  task automatic fwh(input logic w, input logic [3:0] ids, input logic [27:0] a,
                     input logic [3:0] msz, input logic [7:0] d);
    drv(1'b0, w ? 4'hE : 4'hD);
    drv(1'b1, ids);
    for (int i = 6; i >= 0; i--) drv(1'b1, a[i*4 +: 4]);
    drv(1'b1, msz);
    if (w) begin drv(1'b1, d[3:0]); drv(1'b1, d[7:4]); end
  endtask

  task automatic lpc(input logic w, input logic [31:0] a, input logic [7:0] d);
    drv(1'b0, 4'h0);
    drv(1'b1, w ? 4'h6 : 4'h4);
    for (int i = 7; i >= 0; i--) drv(1'b1, a[i*4 +: 4]);
    if (w) begin drv(1'b1, d[3:0]); drv(1'b1, d[7:4]); end
  endtask

  task automatic resp(input logic claimed, input logic w, input logic [7:0] rd,
                      input string t);
    drv(1'b1, 4'hF);
    drv(1'b1, 4'hF);
    if (claimed) begin
      drvc(1'b1, 4'hF, 1'b1, 4'h0, t);
      if (!w) begin
        drvc(1'b1, 4'hF, 1'b1, rd[3:0], t);
        drvc(1'b1, 4'hF, 1'b1, rd[7:4], t);
      end
      drvc(1'b1, 4'hF, 1'b1, 4'hF, t);
      drvc(1'b1, 4'hF, 1'b0, 4'h0, t);
    end else begin
      for (int i = 0; i < 5; i++) drvc(1'b1, 4'hF, 1'b0, 4'h0, t);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    nchk++;
    if (lad_oe !== 1'b0 || req_valid !== 1'b0) begin
      nfail++;
      $display("FAIL R1 reset: got oe=%b req=%b expected 0/0", lad_oe, req_valid);
    end
    rst_n = 1'b1;
    drvc(1'b1, 4'hF, 1'b0, 4'h0, "R1");

    // firmware-memory read to core, then to registers
    core_rdata = 8'h5A;
    expect_req(1'b0, 1'b1, 19'h54321, 8'h00, "R2 R9");
    fwh(1'b0, 4'hA, 28'h7C54321, 4'h0, 8'h00);
    resp(1'b1, 1'b0, 8'h5A, "R2");
    core_rdata = 8'hC3;
    expect_req(1'b0, 1'b0, 19'h000FF, 8'h00, "R9");
    fwh(1'b0, 4'hA, 28'h0B000FF, 4'h0, 8'h00);
    resp(1'b1, 1'b0, 8'hC3, "R9");

    // firmware-memory write
    expect_req(1'b1, 1'b1, 19'h54321, 8'hB7, "R3");
    fwh(1'b1, 4'hA, 28'h7C54321, 4'h0, 8'hB7);
    resp(1'b1, 1'b1, 8'h00, "R3");

    // ID mismatch, bad size
    fwh(1'b0, 4'h3, 28'h7C54321, 4'h0, 8'h00);
    resp(1'b0, 1'b0, 8'h00, "R4");
    fwh(1'b1, 4'hA, 28'h7C54321, 4'h1, 8'h11);
    resp(1'b0, 1'b1, 8'h00, "R5");

    // LPC memory cycles
    core_rdata = 8'h96;
    expect_req(1'b0, 1'b1, 19'h12345, 8'h00, "R6");
    lpc(1'b0, 32'hFFD1_2345, 8'h00);
    resp(1'b1, 1'b0, 8'h96, "R6");
    expect_req(1'b1, 1'b0, 19'h10002, 8'h3C, "R6 R9");
    lpc(1'b1, 32'hFF91_0002, 8'h3C);
    resp(1'b1, 1'b1, 8'h00, "R6");
    lpc(1'b0, 32'hFFD9_0000, 8'h00);
    resp(1'b0, 1'b0, 8'h00, "R7");
    lpc(1'b0, 32'h7FD1_0000, 8'h00);
    resp(1'b0, 1'b0, 8'h00, "R8");
    id_strap = 4'h1;
    core_rdata = 8'h4E;
    expect_req(1'b0, 1'b0, 19'h61234, 8'h00, "R8");
    lpc(1'b0, 32'h000E_1234, 8'h00);
    resp(1'b1, 1'b0, 8'h4E, "R8");
    lpc(1'b0, 32'h0010_1234, 8'h00);
    resp(1'b0, 1'b0, 8'h00, "R8");
    id_strap = 4'hA;

    // busy: writes finish on the bus without a request, reads still go
    core_busy = 1'b1;
    fwh(1'b1, 4'hA, 28'h7C54321, 4'h0, 8'hEE);
    resp(1'b1, 1'b1, 8'h00, "R10");
    lpc(1'b1, 32'hFFD1_2345, 8'h77);
    resp(1'b1, 1'b1, 8'h00, "R10");
    core_rdata = 8'h21;
    expect_req(1'b0, 1'b1, 19'h12345, 8'h00, "R10");
    lpc(1'b0, 32'hFFD1_2345, 8'h00);
    resp(1'b1, 1'b0, 8'h21, "R10");
    core_busy = 1'b0;

    // abort mid-address, then resend
    drv(1'b0, 4'hD); drv(1'b1, 4'hA); drv(1'b1, 4'h7); drv(1'b1, 4'hC);
    drv(1'b0, 4'hF);
    drv(1'b1, 4'hF);
    for (int i = 0; i < 8; i++) drvc(1'b1, 4'hF, 1'b0, 4'h0, "R11");
    core_rdata = 8'h69;
    expect_req(1'b0, 1'b1, 19'h54321, 8'h00, "R11");
    fwh(1'b0, 4'hA, 28'h7C54321, 4'h0, 8'h00);
    resp(1'b1, 1'b0, 8'h69, "R11");

    // abort during write data
    drv(1'b0, 4'hE); drv(1'b1, 4'hA);
    for (int i = 6; i >= 0; i--) drv(1'b1, 4'(28'h7C54321 >> (i*4)));
    drv(1'b1, 4'h0); drv(1'b1, 4'h5);
    drv(1'b0, 4'hF);
    resp(1'b0, 1'b1, 8'h00, "R11");

    // unknown start values
    drv(1'b0, 4'h3); drv(1'b1, 4'hA);
    for (int i = 0; i < 8; i++) drv(1'b1, 4'h7);
    resp(1'b0, 1'b0, 8'h00, "R12");
    drv(1'b0, 4'h9); drv(1'b1, 4'h6);
    for (int i = 0; i < 10; i++) drv(1'b1, 4'hF);
    resp(1'b0, 1'b0, 8'h00, "R12");

    // abort while driving read data
    core_rdata = 8'hA5;
    expect_req(1'b0, 1'b1, 19'h54321, 8'h00, "R14");
    fwh(1'b0, 4'hA, 28'h7C54321, 4'h0, 8'h00);
    drv(1'b1, 4'hF); drv(1'b1, 4'hF);
    drvc(1'b1, 4'hF, 1'b1, 4'h0, "R14");
    drvc(1'b0, 4'hF, 1'b1, 4'h5, "R14");
    drvc(1'b1, 4'hF, 1'b0, 4'h0, "R14");
    drvc(1'b1, 4'hF, 1'b0, 4'h0, "R14");

    repeat (4) @(negedge clk);
    nchk++;
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL R13 missing requests: got %0d pending expected 0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule